// File: doc/BRIEF.md
# PCI Master-Abort Timeout Detector

This block watches the transactions that the local PCI initiator starts and decides when one of them has gone unclaimed. The initiator is idle when FRAME# and IRDY# are both deasserted. When FRAME# then goes low, the block notes whether the command on C/BE# is a Special Cycle broadcast. It then counts PCI clocks while it waits for a target to assert DEVSEL#. If any target claims the cycle, the block stands down. If no target answers within the window, it tells the initiator to end the cycle by master abort. This takes two steps: a one-clock request to deassert FRAME#, then a one-clock request on the next clock to release IRDY#.

A Special Cycle is a broadcast, so it always ends by master abort. That abort is expected: the block terminates the cycle but does not record it and does not report it. Any other command that ends unclaimed sets a sticky received-master-abort status bit and produces a one-clock event pulse. The status bit stays set until a write-one-to-clear strobe removes it.

Top module: `pci_mabort_det`

## Requirements
- R1: After reset the detector is idle, `frame_rel`, `irdy_rel` and `rma_evt` are low and `rma_sts` is clear.
- R2: A supervised transaction starts only on a clock where `frame_n` is sampled low and both `frame_n` and `irdy_n` were sampled high on the previous clock. A FRAME# assertion that follows a clock with `irdy_n` low starts nothing and never leads to an abort.
- R3: If `devsel_n` is sampled low on any of the WAIT_CLKS clocks after the address clock, the timer is cancelled. This includes the last clock of the window. No release pulse follows and `rma_sts` is unchanged.
- R4: If `devsel_n` stays high for all WAIT_CLKS clocks after the address clock, `frame_rel` is high for exactly one clock. That clock is the one right after the WAIT_CLKS-th clock of the window.
- R5: `irdy_rel` is high for exactly one clock, the clock right after the `frame_rel` clock, and the two are never high together.
- R6: An abort of a command other than Special Cycle sets `rma_sts` and pulses `rma_evt` for one clock. Both appear in the same clock as `frame_rel`.
- R7: A command whose `cbe_n` value at the address clock is 4'b0001 (Special Cycle) still receives the `frame_rel` and `irdy_rel` pulses when unclaimed. It leaves `rma_sts` unchanged and raises no `rma_evt`.
- R8: `rma_sts` stays set until `rma_clr` is sampled high. If a new abort sets it on the same clock that `rma_clr` is high, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCI clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_n | input | 1 | FRAME# as seen on the bus |
| irdy_n | input | 1 | IRDY# as seen on the bus |
| devsel_n | input | 1 | DEVSEL# as seen on the bus |
| cbe_n | input | 4 | C/BE# lines, carrying the command at the address clock |
| rma_clr | input | 1 | Write-one-to-clear strobe for the received-master-abort bit |
| frame_rel | output | 1 | One-clock request to the initiator to deassert FRAME# |
| irdy_rel | output | 1 | One-clock request to the initiator to release IRDY# |
| rma_evt | output | 1 | One-clock pulse when a logged master abort occurs |
| rma_sts | output | 1 | Sticky received-master-abort status |

## Verification
The bench builds the block with its default values: a wait window of five clocks and 4'b0001 as the Special Cycle code. With these values a claim can be placed on each of the five window clocks, including the fifth, which is the last one that still cancels the abort. A sixth quiet clock shows that the release pulses start exactly when the window ends. Keeping the Special Cycle code at its default lets the same transaction shape be run once as a broadcast and once as a memory read, so the two can be compared: identical release pulses, but different status behaviour. A clear strobe placed on the abort clock exercises the case where setting and clearing the status bit collide.

// File: rtl/pci_ma_pkg.sv
package pci_ma_pkg;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_WAIT      = 2'd1,
        ST_FRAME_REL = 2'd2,
        ST_IRDY_REL  = 2'd3
    } ma_state_e;

endpackage

// File: rtl/pci_ma_start_det.sv
module pci_ma_start_det #(
    parameter int          CMD_W       = 4,
    parameter logic [3:0]  SPECIAL_CMD = 4'b0001
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             armed,
    input  logic             frame_n,
    input  logic             irdy_n,
    input  logic [CMD_W-1:0] cbe_n,
    output logic             start,
    output logic             start_special
);

    typedef struct packed {
        logic frame_prev;
        logic irdy_prev;
    } hist_t;

    hist_t h_d, h_q;

    always_comb begin
        h_d.frame_prev = frame_n;
        h_d.irdy_prev  = irdy_n;
        start          = armed && h_q.frame_prev && h_q.irdy_prev && !frame_n;
        start_special  = (cbe_n == CMD_W'(SPECIAL_CMD));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            h_q <= '{frame_prev: 1'b1, irdy_prev: 1'b1};
        end else begin
            h_q <= h_d;
        end
    end

    // R2
    start_needs_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> ($past(frame_n) && $past(irdy_n)));

endmodule

// File: rtl/pci_ma_seq.sv
module pci_ma_seq
    import pci_ma_pkg::*;
#(
    parameter int WAIT_CLKS = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic start_special,
    input  logic devsel_n,
    output logic armed,
    output logic abort_fire,
    output logic abort_report,
    output logic frame_rel,
    output logic irdy_rel
);

    localparam int CNT_W = (WAIT_CLKS > 1) ? $clog2(WAIT_CLKS) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WAIT_CLKS - 1);

    typedef struct packed {
        ma_state_e        state;
        logic [CNT_W-1:0] cnt;
        logic             special;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d          = s_q;
        abort_fire   = 1'b0;
        abort_report = 1'b0;
        unique case (s_q.state)
            ST_IDLE: begin
                if (start) begin
                    s_d.state   = ST_WAIT;
                    s_d.cnt     = '0;
                    s_d.special = start_special;
                end
            end
            ST_WAIT: begin
                if (!devsel_n) begin
                    s_d.state = ST_IDLE;
                end else if (s_q.cnt == LAST) begin
                    s_d.state    = ST_FRAME_REL;
                    abort_fire   = 1'b1;
                    abort_report = !s_q.special;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            ST_FRAME_REL: s_d.state = ST_IRDY_REL;
            ST_IRDY_REL:  s_d.state = ST_IDLE;
            default:      s_d.state = ST_IDLE;
        endcase
        armed     = (s_q.state == ST_IDLE);
        frame_rel = (s_q.state == ST_FRAME_REL);
        irdy_rel  = (s_q.state == ST_IRDY_REL);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{state: ST_IDLE, cnt: '0, special: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    // R4
    cnt_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.state == ST_WAIT) |-> (s_q.cnt <= LAST));

    // R3
    claim_cancels_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.state == ST_WAIT && !devsel_n) |=> !frame_rel);

    // R5
    irdy_follows_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_rel |=> (irdy_rel && !frame_rel));

    // R5
    rel_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(frame_rel && irdy_rel));

endmodule

// File: rtl/pci_ma_status.sv
module pci_ma_status (
    input  logic clk,
    input  logic rst_n,
    input  logic report,
    input  logic clr,
    output logic sts,
    output logic evt
);

    typedef struct packed {
        logic sts;
        logic evt;
    } st_t;

    st_t r_d, r_q;

    always_comb begin
        r_d.evt = report;
        if (report) begin
            r_d.sts = 1'b1;
        end else if (clr) begin
            r_d.sts = 1'b0;
        end else begin
            r_d.sts = r_q.sts;
        end
        sts = r_q.sts;
        evt = r_q.evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    // R8
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.sts && !clr) |=> r_q.sts);

    // R6
    evt_sets_sts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt |-> sts);

endmodule

// File: rtl/pci_mabort_det.sv
module pci_mabort_det #(
    parameter int         WAIT_CLKS   = 5,
    parameter int         CMD_W       = 4,
    parameter logic [3:0] SPECIAL_CMD = 4'b0001
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_n,
    input  logic             irdy_n,
    input  logic             devsel_n,
    input  logic [CMD_W-1:0] cbe_n,
    input  logic             rma_clr,
    output logic             frame_rel,
    output logic             irdy_rel,
    output logic             rma_evt,
    output logic             rma_sts
);

    logic armed;
    logic start;
    logic start_special;
    logic abort_fire;
    logic abort_report;

    pci_ma_start_det #(
        .CMD_W       (CMD_W),
        .SPECIAL_CMD (SPECIAL_CMD)
    ) u_start (
        .clk           (clk),
        .rst_n         (rst_n),
        .armed         (armed),
        .frame_n       (frame_n),
        .irdy_n        (irdy_n),
        .cbe_n         (cbe_n),
        .start         (start),
        .start_special (start_special)
    );

    pci_ma_seq #(
        .WAIT_CLKS (WAIT_CLKS)
    ) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .start         (start),
        .start_special (start_special),
        .devsel_n      (devsel_n),
        .armed         (armed),
        .abort_fire    (abort_fire),
        .abort_report  (abort_report),
        .frame_rel     (frame_rel),
        .irdy_rel      (irdy_rel)
    );

    pci_ma_status u_status (
        .clk    (clk),
        .rst_n  (rst_n),
        .report (abort_report),
        .clr    (rma_clr),
        .sts    (rma_sts),
        .evt    (rma_evt)
    );

    // R7
    special_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (abort_fire && !abort_report) |=> !rma_evt);

    // R6
    evt_with_frame_rel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rma_evt |-> frame_rel);

endmodule

// File: tb/sim_pci_mabort_det.sv
`timescale 1ns/1ps
module sim_pci_mabort_det;

    localparam int W = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_n = 1'b1;
    logic       irdy_n = 1'b1;
    logic       devsel_n = 1'b1;
    logic [3:0] cbe_n = 4'hF;
    logic       rma_clr = 1'b0;
    logic       frame_rel, irdy_rel, rma_evt, rma_sts;

    int n_chk = 0;
    int n_bad = 0;
    bit exp_sts = 1'b0;

    always #2.5 clk = ~clk;

    pci_mabort_det u0 (
        .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n),
        .devsel_n(devsel_n), .cbe_n(cbe_n), .rma_clr(rma_clr),
        .frame_rel(frame_rel), .irdy_rel(irdy_rel),
        .rma_evt(rma_evt), .rma_sts(rma_sts)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic idle_bus(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            frame_n = 1'b1; irdy_n = 1'b1; devsel_n = 1'b1; rma_clr = 1'b0; cbe_n = 4'hF;
        end
    endtask

    // claim_at: 0 = no claim, else clock 1..W of the window; clr_at: clock with rma_clr high (0 = none)
    task automatic run_txn(input string req, input logic [3:0] cmd, input int claim_at, input int clr_at);
        bit special = (cmd == 4'b0001);
        @(negedge clk);
        frame_n = 1'b0; cbe_n = cmd;
        for (int k = 1; k <= W; k++) begin
            @(negedge clk);
            chk(req, "no frame_rel inside window", frame_rel, 1'b0);
            irdy_n = 1'b0; cbe_n = 4'h0;
            devsel_n = (k == claim_at) ? 1'b0 : devsel_n;
            rma_clr = (k == clr_at);
        end
        @(negedge clk);
        rma_clr = 1'b0;
        if (claim_at == 0) begin
            if (!special) exp_sts = 1'b1;
            else if (clr_at == W) exp_sts = 1'b0;
            chk(req, "frame_rel after window", frame_rel, 1'b1);
            chk(req, "irdy_rel not with frame_rel", irdy_rel, 1'b0);
            chk(req, "rma_evt", rma_evt, !special);
            chk(req, "rma_sts", rma_sts, exp_sts);
            frame_n = 1'b1;
            @(negedge clk);
            chk("R5", "irdy_rel after frame_rel", irdy_rel, 1'b1);
            chk("R5", "frame_rel single clock", frame_rel, 1'b0);
            chk(req, "rma_evt single clock", rma_evt, 1'b0);
            irdy_n = 1'b1;
            @(negedge clk);
            chk("R5", "irdy_rel single clock", irdy_rel, 1'b0);
        end else begin
            if (clr_at != 0) exp_sts = 1'b0;
            chk(req, "no frame_rel after claim", frame_rel, 1'b0);
            chk(req, "rma_sts unchanged", rma_sts, exp_sts);
            @(negedge clk);
            chk(req, "no irdy_rel after claim", irdy_rel, 1'b0);
            chk(req, "no rma_evt after claim", rma_evt, 1'b0);
        end
        idle_bus(2);
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk("R1", "frame_rel", frame_rel, 1'b0);
        chk("R1", "irdy_rel", irdy_rel, 1'b0);
        chk("R1", "rma_evt", rma_evt, 1'b0);
        chk("R1", "rma_sts", rma_sts, 1'b0);
    endtask

    task automatic t_claims;
        for (int k = 1; k <= W; k++) run_txn("R3", 4'b0110, k, 0);
    endtask

    task automatic t_not_idle;
        @(negedge clk);
        irdy_n = 1'b0;
        @(negedge clk);
        frame_n = 1'b0; cbe_n = 4'b0110;
        for (int k = 0; k < W + 3; k++) begin
            @(negedge clk);
            chk("R2", "no abort without idle bus", frame_rel | irdy_rel | rma_evt, 1'b0);
        end
        chk("R2", "rma_sts untouched", rma_sts, exp_sts);
        idle_bus(2);
    endtask

    task automatic t_special;
        run_txn("R7", 4'b0001, 0, 0);
        chk("R7", "special leaves rma_sts clear", rma_sts, 1'b0);
    endtask

    task automatic t_logged;
        run_txn("R4", 4'b0110, 0, 0);
        run_txn("R6", 4'b0111, 0, 0);
    endtask

    task automatic t_sticky;
        idle_bus(4);
        chk("R8", "rma_sts held while idle", rma_sts, 1'b1);
        run_txn("R8", 4'b0110, 2, 0);
        chk("R8", "rma_sts held across claimed cycle", rma_sts, 1'b1);
        @(negedge clk);
        rma_clr = 1'b1;
        @(negedge clk);
        rma_clr = 1'b0;
        exp_sts = 1'b0;
        chk("R8", "rma_clr clears", rma_sts, 1'b0);
        run_txn("R8", 4'b0110, 0, W);
        chk("R8", "set wins over clear", rma_sts, 1'b1);
    endtask

    initial begin : main
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        idle_bus(2);
        t_reset();
        t_claims();
        t_not_idle();
        t_special();
        t_logged();
        t_sticky();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule